// File: doc/BRIEF.md
# Card Clock Source Selector

This block produces the clock that drives a smart card, together with a clock returned to the host controller. Three sources are available: an external strobe level from the host, a crystal oscillator, and an internal RC oscillator. A select input and a two-bit divide code choose the source and the ratio. One code value holds the card clock stopped LOW. A low-power flag puts the block into its sleep arrangement: the card clock stops and the host clock is taken from the slowed internal oscillator.

The design runs on one system clock. Each oscillator appears as an enable input that pulses once per half-period of that oscillator, so an output that toggles on every N-th pulse runs at the oscillator frequency divided by N. Both outputs are registered. Either output changes source or ratio only while it is LOW, which keeps every pulse at least half a period long. The divider count restarts at each change.

Top module: `card_clk_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `card_clk` and `host_clk` are LOW.
- R2: With `sel_strobe`=1 and `low_pwr`=0, `card_clk` equals the `strobe_i` value sampled at the previous clock edge, whatever `div_code` holds.
- R3: With `sel_strobe`=0, `low_pwr`=0 and `div_code`=2'b10, `card_clk` toggles on every second `rc_tick` pulse (half the internal frequency) and never in a cycle with no tick.
- R4: With `sel_strobe`=0 and `low_pwr`=0, `div_code`=2'b00 toggles `card_clk` on every fourth `xtal_tick` pulse (quarter crystal frequency), and `div_code`=2'b01 toggles it on every second pulse (half crystal frequency).
- R5: With `sel_strobe`=0, `low_pwr`=0 and `div_code`=2'b11, `card_clk` is held LOW once it is LOW.
- R6: With `low_pwr`=0, `host_clk` toggles on every `xtal_tick` pulse (crystal frequency) unless `div_code`=2'b10, in which case it toggles on every second `rc_tick` pulse. `sel_strobe` has no effect on it. `host_clk` changes only in a cycle after a tick.
- R7: With `low_pwr`=1, `card_clk` is held LOW once it is LOW, and `host_clk` toggles on every second `rc_tick` pulse, whatever `sel_strobe` and `div_code` hold.
- R8: When the requested source or ratio of an output changes while that output is HIGH, the output keeps its old setting until it has fallen. The new setting takes hold in the first cycle in which the output is LOW. The output stays LOW in that cycle, and the tick count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_strobe | input | 1 | 1: card clock follows the strobe input |
| div_code | input | 2 | Source and ratio code when `sel_strobe` is 0 |
| low_pwr | input | 1 | Sleep arrangement active |
| strobe_i | input | 1 | External clock level from the host |
| xtal_tick | input | 1 | One pulse per half-period of the crystal oscillator |
| rc_tick | input | 1 | One pulse per half-period of the RC oscillator |
| card_clk | output | 1 | Clock to the card |
| host_clk | output | 1 | Clock back to the host |

## Verification
The two functions that meet in one cycle are a source or ratio change and a divider toggle that is due. The bench changes `div_code`, `sel_strobe` and `low_pwr` while the outputs are HIGH and in the same cycle as a tick pulse, with tick spacings that do not share a period with the changes. A behavioural model holds the old setting until its own output is LOW, restarts its count, and is compared with both outputs on every cycle. A late switch, an early switch or a count that is not restarted shows up as a mismatch.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [2:0] {
    SRC_STOP   = 3'd0,
    SRC_STROBE = 3'd1,
    SRC_XT_Q   = 3'd2,
    SRC_XT_H   = 3'd3,
    SRC_RC_H   = 3'd4,
    SRC_XT_F   = 3'd5
  } src_e;

  function automatic logic src_uses_xtal(input src_e s);
    return (s == SRC_XT_Q) || (s == SRC_XT_H) || (s == SRC_XT_F);
  endfunction
endpackage

// File: rtl/ccs_src_map.sv
module ccs_src_map
  import ccs_pkg::*;
(
  input  logic       sel_strobe,
  input  logic [1:0] div_code,
  input  logic       low_pwr,
  output src_e       card_req,
  output src_e       host_req
);
  always_comb begin
    if (low_pwr) begin
      card_req = SRC_STOP;
    end else if (sel_strobe) begin
      card_req = SRC_STROBE;
    end else begin
      unique case (div_code)
        2'b00:   card_req = SRC_XT_Q;
        2'b01:   card_req = SRC_XT_H;
        2'b10:   card_req = SRC_RC_H;
        default: card_req = SRC_STOP;
      endcase
    end
  end

  always_comb begin
    if (low_pwr || (div_code == 2'b10)) host_req = SRC_RC_H;
    else                                host_req = SRC_XT_F;
  end
endmodule

// File: rtl/ccs_clk_gen.sv
module ccs_clk_gen
  import ccs_pkg::*;
#(
  parameter int XT_Q_DIV = 4,
  parameter int XT_H_DIV = 2,
  parameter int RC_H_DIV = 2,
  parameter int XT_F_DIV = 1,
  parameter int CNT_W    = 3
) (
  input  logic clk,
  input  logic rst,
  input  src_e req,
  input  logic strobe_i,
  input  logic xtal_tick,
  input  logic rc_tick,
  output logic clk_q
);
  src_e             cur;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             tick;
  logic             swap;

  always_comb begin
    unique case (cur)
      SRC_XT_Q: last = CNT_W'(XT_Q_DIV - 1);
      SRC_XT_H: last = CNT_W'(XT_H_DIV - 1);
      SRC_RC_H: last = CNT_W'(RC_H_DIV - 1);
      SRC_XT_F: last = CNT_W'(XT_F_DIV - 1);
      default:  last = '0;
    endcase
    tick = src_uses_xtal(cur) ? xtal_tick : rc_tick;
    swap = (cur != req) && !clk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= SRC_STOP;
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (swap) begin
      cur   <= req;
      cnt   <= '0;
      clk_q <= 1'b0;
    end else begin
      unique case (cur)
        SRC_STOP:   clk_q <= 1'b0;
        SRC_STROBE: clk_q <= strobe_i;
        default: begin
          if (tick) begin
            if (cnt == last) begin
              cnt   <= '0;
              clk_q <= ~clk_q;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
  import ccs_pkg::*;
#(
  parameter int XT_SLOW_DIV = 4,
  parameter int XT_FAST_DIV = 2,
  parameter int RC_DIV      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_strobe,
  input  logic [1:0] div_code,
  input  logic       low_pwr,
  input  logic       strobe_i,
  input  logic       xtal_tick,
  input  logic       rc_tick,
  output logic       card_clk,
  output logic       host_clk
);
  localparam int MAX_DIV = (XT_SLOW_DIV > XT_FAST_DIV) ?
                           ((XT_SLOW_DIV > RC_DIV) ? XT_SLOW_DIV : RC_DIV) :
                           ((XT_FAST_DIV > RC_DIV) ? XT_FAST_DIV : RC_DIV);
  localparam int CNT_W = $clog2(MAX_DIV) + 1;

  src_e card_req;
  src_e host_req;

  ccs_src_map u_map (
    .sel_strobe (sel_strobe),
    .div_code   (div_code),
    .low_pwr    (low_pwr),
    .card_req   (card_req),
    .host_req   (host_req)
  );

  ccs_clk_gen #(
    .XT_Q_DIV (XT_SLOW_DIV),
    .XT_H_DIV (XT_FAST_DIV),
    .RC_H_DIV (RC_DIV),
    .XT_F_DIV (1),
    .CNT_W    (CNT_W)
  ) u_card (
    .clk       (clk),
    .rst       (rst),
    .req       (card_req),
    .strobe_i  (strobe_i),
    .xtal_tick (xtal_tick),
    .rc_tick   (rc_tick),
    .clk_q     (card_clk)
  );

  ccs_clk_gen #(
    .XT_Q_DIV (XT_SLOW_DIV),
    .XT_H_DIV (XT_FAST_DIV),
    .RC_H_DIV (RC_DIV),
    .XT_F_DIV (1),
    .CNT_W    (CNT_W)
  ) u_host (
    .clk       (clk),
    .rst       (rst),
    .req       (host_req),
    .strobe_i  (1'b0),
    .xtal_tick (xtal_tick),
    .rc_tick   (rc_tick),
    .clk_q     (host_clk)
  );
endmodule

// File: rtl/card_clk_sel_chk.sv
module card_clk_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_strobe,
  input logic [1:0] div_code,
  input logic       low_pwr,
  input logic       strobe_i,
  input logic       xtal_tick,
  input logic       rc_tick,
  input logic       card_clk,
  input logic       host_clk
);
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!card_clk && !host_clk));

  assert_stop_code_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_strobe && !low_pwr && div_code == 2'b11 && !card_clk) |=> !card_clk);

  assert_sleep_card_R7: assert property (@(posedge clk) disable iff (rst)
    (low_pwr && !card_clk) |=> !card_clk);

  // R3: without a tick, and with strobe equal to the output, the card clock holds
  assert_card_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!xtal_tick && !rc_tick && (strobe_i == card_clk)) |=> $stable(card_clk));

  assert_host_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (!xtal_tick && !rc_tick) |=> $stable(host_clk));
endmodule

bind card_clk_sel card_clk_sel_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_strobe (sel_strobe),
  .div_code   (div_code),
  .low_pwr    (low_pwr),
  .strobe_i   (strobe_i),
  .xtal_tick  (xtal_tick),
  .rc_tick    (rc_tick),
  .card_clk   (card_clk),
  .host_clk   (host_clk)
);

// File: tb/card_clk_sel_bench.sv
module card_clk_sel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_strobe = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic       low_pwr = 1'b0;
  logic       strobe_i = 1'b0;
  logic       xtal_tick = 1'b0;
  logic       rc_tick = 1'b0;
  logic       card_clk;
  logic       host_clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int xt_period = 3;
  int rc_period = 5;

  // model: index 0 card, 1 host; modes 0 stop,1 strobe,2 xtal/4,3 xtal/2,4 rc/2,5 xtal
  int  m_mode[2];
  int  m_cnt[2];
  bit  m_out[2];
  bit  m_swapped[2];

  always #2.5 clk = ~clk;

  card_clk_sel u_card_clk_sel (
    .clk(clk), .rst(rst), .sel_strobe(sel_strobe), .div_code(div_code),
    .low_pwr(low_pwr), .strobe_i(strobe_i), .xtal_tick(xtal_tick),
    .rc_tick(rc_tick), .card_clk(card_clk), .host_clk(host_clk)
  );

  function automatic int want_mode(int idx);
    if (idx == 1) return (low_pwr || div_code == 2'b10) ? 4 : 5;
    if (low_pwr) return 0;
    if (sel_strobe) return 1;
    case (div_code)
      2'b00: return 2;
      2'b01: return 3;
      2'b10: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int ratio(int md);
    case (md)
      2: return 4;
      3: return 2;
      4: return 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      m_swapped[i] = 1'b0;
      if (rst) begin
        m_mode[i] = 0; m_cnt[i] = 0; m_out[i] = 1'b0;
      end else if (want_mode(i) != m_mode[i] && !m_out[i]) begin
        m_mode[i] = want_mode(i); m_cnt[i] = 0; m_out[i] = 1'b0;
        m_swapped[i] = 1'b1;
      end else if (m_mode[i] == 0) begin
        m_out[i] = 1'b0;
      end else if (m_mode[i] == 1) begin
        m_out[i] = strobe_i;
      end else if ((m_mode[i] == 4) ? rc_tick : xtal_tick) begin
        m_cnt[i]++;
        if (m_cnt[i] == ratio(m_mode[i])) begin
          m_cnt[i] = 0;
          m_out[i] = !m_out[i];
        end
      end
    end
  end

  function automatic string tag(int idx);
    if (m_swapped[idx]) return "R8";
    if (rst) return "R1";
    if (idx == 1) return low_pwr ? "R7" : "R6";
    if (low_pwr) return "R7";
    case (m_mode[0])
      1: return "R2";
      2, 3: return "R4";
      4: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  // compare on every falling edge, then drive the next inputs
  always @(negedge clk) begin
    cyc++;
    check(tag(0), "card_clk", card_clk, m_out[0]);
    check(tag(1), "host_clk", host_clk, m_out[1]);
    xtal_tick <= (cyc % xt_period) == 0;
    rc_tick   <= (cyc % rc_period) == 0;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_strobe(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      strobe_i <= ((k * 7) % 5) < 2;
    end
  endtask

  int toggles;
  logic prev;

  initial begin
    // R1: reset state
    wait_cyc(3);
    check("R1", "card_clk in reset", card_clk, 1'b0);
    check("R1", "host_clk in reset", host_clk, 1'b0);
    @(negedge clk); rst <= 1'b0;
    @(negedge clk);
    check("R1", "card_clk after reset", card_clk, 1'b0);
    check("R1", "host_clk after reset", host_clk, 1'b0);

    // R4: quarter crystal, count toggles over 120 cycles (40 ticks -> 10)
    div_code <= 2'b00;
    wait_cyc(30);
    toggles = 0;
    prev = card_clk;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (card_clk != prev) toggles++;
      prev = card_clk;
    end
    checks++;
    if (toggles < 9 || toggles > 11) begin
      errors++;
      $display("FAIL R4 quarter rate toggles: actual=%0d expected=10", toggles);
    end

    // R4 half crystal, R3 rc, R5 stop
    div_code <= 2'b01; wait_cyc(80);
    div_code <= 2'b10; wait_cyc(100);
    div_code <= 2'b11; wait_cyc(60);
    check("R5", "card held low", card_clk, 1'b0);

    // R2: strobe with div changing underneath
    sel_strobe <= 1'b1;
    fork
      run_strobe(150);
      begin
        for (int k = 0; k < 5; k++) begin
          wait_cyc(29);
          div_code <= 2'(k);
        end
      end
    join

    // R8: changes aimed at cycles where outputs are high and ticks coincide
    sel_strobe <= 1'b0;
    xt_period = 2; rc_period = 3;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      wait (card_clk == 1'b1 || host_clk == 1'b1);
      div_code <= 2'((k * 3) % 4);
      wait_cyc(1 + (k % 7));
    end
    wait_cyc(40);

    // R7: sleep with slow rc ticks
    rc_period = 16;
    low_pwr <= 1'b1;
    for (int k = 0; k < 4; k++) begin
      sel_strobe <= k[0];
      div_code <= 2'(k);
      wait_cyc(90);
    end
    check("R7", "card held low in sleep", card_clk, 1'b0);

    // leave sleep with strobe selected, high strobe
    rc_period = 5; xt_period = 3;
    low_pwr <= 1'b0;
    sel_strobe <= 1'b1;
    strobe_i <= 1'b1;
    wait_cyc(5);
    check("R2", "card follows high strobe", card_clk, 1'b1);
    // drop select while high strobe holds the card clock high
    sel_strobe <= 1'b0; div_code <= 2'b01;
    wait_cyc(10);
    check("R8", "old source kept while high", card_clk, 1'b1);
    strobe_i <= 1'b0;
    wait_cyc(60);

    // reset in mid-run
    rst <= 1'b1;
    wait_cyc(2);
    check("R1", "card_clk in second reset", card_clk, 1'b0);
    check("R1", "host_clk in second reset", host_clk, 1'b0);
    rst <= 1'b0;
    wait_cyc(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule